// File: doc/BRIEF.md
# SPI Flash Controller Register and Interrupt Unit

This block is the register front end of a SPI flash master. A host performs 32-bit, word-aligned writes and combinational reads through a simple write-strobe port. The block holds the static configuration that a separate serial engine consumes: master mode, clock polarity and phase, a baud divisor code, a FIFO word width, an active-low slave-select field, manual chip-select and manual-start enables, flash interface mode, and a global controller enable. It also holds two FIFO-level thresholds.

The FIFOs live elsewhere and report only their fill levels. This unit compares those levels against the thresholds and against the FIFO depth. It latches each result into a sticky interrupt status word, which software clears by writing ones. An interrupt mask is never written directly. One register sets mask bits and another clears them. A single interrupt line is raised whenever any status bit is set while its mask bit is set.

Register offsets (byte addresses): control 0x00, status 0x04, mask-set 0x08, mask-clear 0x0C, mask readback 0x10, controller enable 0x14, TX threshold 0x28, RX threshold 0x2C.

Top module: `sfc_csr_top`

## Requirements
- R1: After reset the registers read as follows: control 0x8000_3C09 (master mode, divide-by-4 baud code 1, all four selects high, flash interface mode), status 0, mask 0, enable 0, TX threshold 1 and RX threshold 1. The irq output is 0.
- R2: Control bits are mapped as follows: bit 0 master mode, bit 1 clock polarity, bit 2 clock phase, bits 5:3 baud code, bits 7:6 word width, bits 13:10 select field, bit 14 manual chip select, bit 15 manual start, bit 31 flash interface mode. A write stores these fields and drives the matching outputs after the write edge. Control bits 8, 9 and 30:16 read as 0.
- R3: ss_n equals control bits 13:10 bit for bit. A low bit selects that slave, and all ones deselects every slave.
- R4: Enable register bit 0 drives ctl_enable. The other bits of that register read as 0.
- R5: Writing to 0x08 sets each mask bit whose wdata bit is 1 and leaves the other mask bits unchanged. Reading 0x08 returns 0.
- R6: Writing to 0x0C clears each mask bit whose wdata bit is 1. Reading 0x0C returns 0. The 7-bit mask reads at 0x10, and writes to 0x10 are ignored.
- R7: Status bits are captured on the clock edge after their condition holds. The conditions are: bit 0 when the RX level is at or above the RX threshold; bit 2 when the TX level is below the TX threshold; bit 3 when the TX level equals FIFO_DEPTH; bit 4 when the RX level is nonzero; bit 5 when the RX level equals FIFO_DEPTH. Bits 1, 6 and 31:7 read as 0.
- R8: A status bit stays set after its condition goes away, until it is cleared.
- R9: Writing ones to 0x04 clears those status bits on that edge, even if the condition still holds. A bit whose condition still holds sets again on the following edge.
- R10: irq is 1 exactly when some status bit and its mask bit are both 1.
- R11: The thresholds are LVL_W bits wide and are written from the low LVL_W bits of wdata. Reads of any other offset return 0, and writes to other offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| tx_level | input | LVL_W | TX FIFO fill level |
| rx_level | input | LVL_W | RX FIFO fill level |
| ctl_enable | output | 1 | Controller enable |
| master_mode | output | 1 | Master mode select |
| clk_pol | output | 1 | Serial clock polarity |
| clk_pha | output | 1 | Serial clock phase |
| baud_code | output | 3 | Baud divisor code |
| word_width | output | 2 | FIFO word width code |
| ss_n | output | 4 | Active-low slave selects |
| manual_cs | output | 1 | Manual chip-select enable |
| manual_start | output | 1 | Manual start enable |
| flash_if_mode | output | 1 | Flash interface mode |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with FIFO_DEPTH set to 8, so LVL_W is 4. This lets a 4-bit level reach both the full-FIFO conditions and the threshold saturation value 0xF without long fills. ADDR_W keeps its default of 8, which covers every defined offset and also unused offsets such as 0x30 and 0x34. The directed part holds a level condition across a clear write. This exposes the clear-wins edge followed by the set on the next edge, and it shows the masked and unmasked behaviour of irq.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int NREG   = 8;
    localparam int STAT_W = 7;

    localparam int IX_CTRL  = 0;
    localparam int IX_STAT  = 1;
    localparam int IX_MSET  = 2;
    localparam int IX_MCLR  = 3;
    localparam int IX_MASK  = 4;
    localparam int IX_ENA   = 5;
    localparam int IX_TXTHR = 6;
    localparam int IX_RXTHR = 7;

    localparam logic [7:0] REG_OFF [NREG] = '{
        8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h28, 8'h2C
    };

    localparam int ST_RX_THR  = 0;
    localparam int ST_TX_LOW  = 2;
    localparam int ST_TX_FULL = 3;
    localparam int ST_RX_NE   = 4;
    localparam int ST_RX_FULL = 5;

    typedef struct packed {
        logic       flash_if;
        logic       man_start;
        logic       man_cs;
        logic [3:0] sel_n;
        logic [1:0] wwidth;
        logic [2:0] baud;
        logic       pha;
        logic       pol;
        logic       master;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        flash_if: 1'b1, man_start: 1'b0, man_cs: 1'b0, sel_n: 4'hF,
        wwidth: 2'd0, baud: 3'd1, pha: 1'b0, pol: 1'b0, master: 1'b1
    };

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w        = '0;
        w[0]     = c.master;
        w[1]     = c.pol;
        w[2]     = c.pha;
        w[5:3]   = c.baud;
        w[7:6]   = c.wwidth;
        w[13:10] = c.sel_n;
        w[14]    = c.man_cs;
        w[15]    = c.man_start;
        w[31]    = c.flash_if;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.master    = w[0];
        c.pol       = w[1];
        c.pha       = w[2];
        c.baud      = w[5:3];
        c.wwidth    = w[7:6];
        c.sel_n     = w[13:10];
        c.man_cs    = w[14];
        c.man_start = w[15];
        c.flash_if  = w[31];
        return c;
    endfunction

endpackage

// File: rtl/sfc_addr_dec.sv
module sfc_addr_dec
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel
);

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign sel[i] = (addr == ADDR_W'(REG_OFF[i]));
    end

endmodule

// File: rtl/sfc_ctrl_regs.sv
module sfc_ctrl_regs
    import sfc_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NREG-1:0]  sel,
    input  logic [31:0]      wdata,
    output ctrl_t            ctrl_q,
    output logic             en_q,
    output logic [LVL_W-1:0] txthr_q,
    output logic [LVL_W-1:0] rxthr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            en_q    <= 1'b0;
            txthr_q <= LVL_W'(1);
            rxthr_q <= LVL_W'(1);
        end else if (wr_en) begin
            if (sel[IX_CTRL])  ctrl_q  <= word_to_ctrl(wdata);
            if (sel[IX_ENA])   en_q    <= wdata[0];
            if (sel[IX_TXTHR]) txthr_q <= wdata[LVL_W-1:0];
            if (sel[IX_RXTHR]) rxthr_q <= wdata[LVL_W-1:0];
        end
    end

    // R11: a write that hits no register leaves all configuration untouched
    a_r11_undef_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == '0) |=> ($stable(ctrl_q) && $stable(en_q)
                                  && $stable(txthr_q) && $stable(rxthr_q)));

    // R4: enable follows bit 0 of its write
    a_r4_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[IX_ENA]) |=> (en_q == $past(wdata[0])));

endmodule

// File: rtl/sfc_irq_unit.sv
module sfc_irq_unit
    import sfc_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int LVL_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NREG-1:0]   sel,
    input  logic [STAT_W-1:0] wdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  txthr,
    input  logic [LVL_W-1:0]  rxthr,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

    logic [STAT_W-1:0] cond;
    logic              clr_hit;
    logic              set_hit;
    logic              mclr_hit;

    assign clr_hit  = wr_en && sel[IX_STAT];
    assign set_hit  = wr_en && sel[IX_MSET];
    assign mclr_hit = wr_en && sel[IX_MCLR];

    always_comb begin
        cond             = '0;
        cond[ST_RX_THR]  = (rx_level >= rxthr);
        cond[ST_TX_LOW]  = (tx_level < txthr);
        cond[ST_TX_FULL] = (tx_level == FULL_LVL);
        cond[ST_RX_NE]   = (rx_level != '0);
        cond[ST_RX_FULL] = (rx_level == FULL_LVL);
    end

    for (genvar i = 0; i < STAT_W; i++) begin : g_stat
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   bit_q <= 1'b0;
            else if (clr_hit && wdata[i]) bit_q <= 1'b0;
            else if (cond[i])             bit_q <= 1'b1;
        end
        assign status_q[i] = bit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask_q <= '0;
        else if (set_hit)  mask_q <= mask_q | wdata;
        else if (mclr_hit) mask_q <= mask_q & ~wdata;
    end

    assign irq = |(status_q & mask_q);

    // R5: every bit written as one into the set register is set afterwards
    a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> ((mask_q & $past(wdata)) == $past(wdata)));

    // R6: every bit written as one into the clear register is clear afterwards
    a_r6_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_hit |=> ((mask_q & $past(wdata)) == '0));

    // R9: a clear write wins on its own edge
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((status_q & $past(wdata)) == '0));

    // R8: without a clear write no status bit falls
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R10: an interrupt needs at least one enabled source
    a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));

endmodule

// File: rtl/sfc_csr_top.sv
module sfc_csr_top
    import sfc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 64,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              ctl_enable,
    output logic              master_mode,
    output logic              clk_pol,
    output logic              clk_pha,
    output logic [2:0]        baud_code,
    output logic [1:0]        word_width,
    output logic [3:0]        ss_n,
    output logic              manual_cs,
    output logic              manual_start,
    output logic              flash_if_mode,
    output logic              irq
);

    logic [NREG-1:0]   sel;
    ctrl_t             ctrl_q;
    logic              en_q;
    logic [LVL_W-1:0]  txthr_q;
    logic [LVL_W-1:0]  rxthr_q;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] mask_q;

    sfc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    sfc_ctrl_regs #(.LVL_W(LVL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (wdata),
        .ctrl_q  (ctrl_q),
        .en_q    (en_q),
        .txthr_q (txthr_q),
        .rxthr_q (rxthr_q)
    );

    sfc_irq_unit #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel      (sel),
        .wdata    (wdata[STAT_W-1:0]),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .txthr    (txthr_q),
        .rxthr    (rxthr_q),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    always_comb begin
        rdata = '0;
        if (sel[IX_CTRL])  rdata = ctrl_to_word(ctrl_q);
        if (sel[IX_STAT])  rdata = 32'(status_q);
        if (sel[IX_MASK])  rdata = 32'(mask_q);
        if (sel[IX_ENA])   rdata = 32'(en_q);
        if (sel[IX_TXTHR]) rdata = 32'(txthr_q);
        if (sel[IX_RXTHR]) rdata = 32'(rxthr_q);
    end

    assign ctl_enable    = en_q;
    assign master_mode   = ctrl_q.master;
    assign clk_pol       = ctrl_q.pol;
    assign clk_pha       = ctrl_q.pha;
    assign baud_code     = ctrl_q.baud;
    assign word_width    = ctrl_q.wwidth;
    assign ss_n          = ctrl_q.sel_n;
    assign manual_cs     = ctrl_q.man_cs;
    assign manual_start  = ctrl_q.man_start;
    assign flash_if_mode = ctrl_q.flash_if;

endmodule

// File: tb/sfc_csr_top_test.sv
module sfc_csr_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int LW         = 4;
    localparam int NV         = 15;

    // {write offset, write data, read offset, expected read}
    localparam logic [79:0] VEC [NV] = '{
        {8'h00, 32'hFFFF_FFFF, 8'h00, 32'h8000_FCFF},
        {8'h00, 32'h0000_0000, 8'h00, 32'h0000_0000},
        {8'h00, 32'h0000_3816, 8'h00, 32'h0000_3816},
        {8'h14, 32'hFFFF_FFFF, 8'h14, 32'h0000_0001},
        {8'h14, 32'h0000_0000, 8'h14, 32'h0000_0000},
        {8'h28, 32'hFFFF_FFFF, 8'h28, 32'h0000_000F},
        {8'h28, 32'h0000_0005, 8'h28, 32'h0000_0005},
        {8'h2C, 32'h0000_0003, 8'h2C, 32'h0000_0003},
        {8'h10, 32'h0000_007F, 8'h10, 32'h0000_0000},
        {8'h08, 32'h0000_0014, 8'h08, 32'h0000_0000},
        {8'h0C, 32'h0000_0004, 8'h10, 32'h0000_0010},
        {8'h08, 32'hFFFF_FFFF, 8'h10, 32'h0000_007F},
        {8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000},
        {8'h34, 32'hFFFF_FFFF, 8'h34, 32'h0000_0000},
        {8'h34, 32'hFFFF_FFFF, 8'h00, 32'h0000_3816}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [LW-1:0] tx_level = LW'(4);
    logic [LW-1:0] rx_level = '0;
    logic          ctl_enable, master_mode, clk_pol, clk_pha;
    logic [2:0]    baud_code;
    logic [1:0]    word_width;
    logic [3:0]    ss_n;
    logic          manual_cs, manual_start, flash_if_mode, irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfc_csr_top #(.ADDR_W(8), .FIFO_DEPTH(DEPTH)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .addr          (addr),
        .wdata         (wdata),
        .rdata         (rdata),
        .tx_level      (tx_level),
        .rx_level      (rx_level),
        .ctl_enable    (ctl_enable),
        .master_mode   (master_mode),
        .clk_pol       (clk_pol),
        .clk_pha       (clk_pha),
        .baud_code     (baud_code),
        .word_width    (word_width),
        .ss_n          (ss_n),
        .manual_cs     (manual_cs),
        .manual_start  (manual_start),
        .flash_if_mode (flash_if_mode),
        .irq           (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    function automatic string vtag(input logic [7:0] a);
        case (a)
            8'h00:   return "R2 table";
            8'h14:   return "R4 table";
            8'h08:   return "R5 table";
            8'h0C,
            8'h10:   return "R6 table";
            default: return "R11 table";
        endcase
    endfunction

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd_chk("R1 control", 8'h00, 32'h8000_3C09);
        rd_chk("R1 status",  8'h04, 32'h0);
        rd_chk("R1 mask",    8'h10, 32'h0);
        rd_chk("R1 enable",  8'h14, 32'h0);
        rd_chk("R1 txthr",   8'h28, 32'h1);
        rd_chk("R1 rxthr",   8'h2C, 32'h1);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 ss_n", 32'(ss_n), 32'hF);
        chk("R1 baud", 32'(baud_code), 32'h1);
        chk("R1 master/flash", {30'b0, master_mode, flash_if_mode}, 32'h3);
        tick();
        rd_chk("R1 status idle", 8'h04, 32'h0);

        // table walk: write, then read back
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][79:72], VEC[i][71:40]);
            rd_chk(vtag(VEC[i][39:32]), VEC[i][39:32], VEC[i][31:0]);
        end

        // R2 / R3: configuration outputs
        wr(8'h00, 32'h0000_2C9E);
        chk("R3 ss_n", 32'(ss_n), 32'hB);
        chk("R2 baud", 32'(baud_code), 32'h3);
        chk("R2 width", 32'(word_width), 32'h2);
        chk("R2 pol/pha/master", {29'b0, clk_pol, clk_pha, master_mode}, 32'h6);
        chk("R2 mcs/mstart/flash", {29'b0, manual_cs, manual_start, flash_if_mode}, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        chk("R3 deselect", 32'(ss_n), 32'hF);
        chk("R2 mcs/mstart/flash set", {29'b0, manual_cs, manual_start, flash_if_mode}, 32'h7);

        // R4: enable output
        wr(8'h14, 32'h0000_0001);
        chk("R4 ctl_enable on", 32'(ctl_enable), 32'h1);
        wr(8'h14, 32'hFFFF_FFFE);
        chk("R4 ctl_enable off", 32'(ctl_enable), 32'h0);

        // R11: undefined offsets
        wr(8'h30, 32'hFFFF_FFFF);
        rd_chk("R11 undef read", 8'h30, 32'h0);
        rd_chk("R11 control kept", 8'h00, 32'h8000_FCFF);
        rd_chk("R11 txthr kept", 8'h28, 32'h5);

        // R7 / R8 / R9: TX below threshold
        tx_level = LW'(4);
        rx_level = '0;
        wr(8'h28, 32'h2);
        wr(8'h2C, 32'h3);
        wr(8'h04, 32'h7F);
        rd_chk("R9 clear all", 8'h04, 32'h0);
        tx_level = LW'(1);
        tick();
        rd_chk("R7 tx low", 8'h04, 32'h04);
        tx_level = LW'(4);
        tick();
        rd_chk("R8 sticky", 8'h04, 32'h04);
        wr(8'h04, 32'h04);
        rd_chk("R9 cleared", 8'h04, 32'h0);
        tick();
        rd_chk("R9 stays clear", 8'h04, 32'h0);
        tx_level = LW'(1);
        tick();
        wr(8'h04, 32'h04);
        rd_chk("R9 clear wins", 8'h04, 32'h0);
        tick();
        rd_chk("R9 reassert", 8'h04, 32'h04);

        // R7: RX conditions and full levels
        tx_level = LW'(4);
        wr(8'h04, 32'h7F);
        rx_level = LW'(3);
        tick();
        rd_chk("R7 rx thr+ne", 8'h04, 32'h11);
        rx_level = LW'(DEPTH);
        tick();
        rd_chk("R7 rx full", 8'h04, 32'h31);
        tx_level = LW'(DEPTH);
        tick();
        rd_chk("R7 tx full", 8'h04, 32'h39);
        tx_level = LW'(4);
        rx_level = '0;
        wr(8'h04, 32'h7F);
        rd_chk("R9 clear levels", 8'h04, 32'h0);

        // R10: interrupt combination
        tx_level = LW'(1);
        tick();
        chk("R10 masked", 32'(irq), 32'h0);
        wr(8'h08, 32'h04);
        chk("R10 unmasked", 32'(irq), 32'h1);
        wr(8'h0C, 32'h04);
        chk("R10 remasked", 32'(irq), 32'h0);
        wr(8'h08, 32'h10);
        chk("R10 other source idle", 32'(irq), 32'h0);
        tx_level = LW'(4);
        rx_level = LW'(1);
        tick();
        chk("R10 rx source", 32'(irq), 32'h1);
        wr(8'h04, 32'h10);
        chk("R10 cleared source", 32'(irq), 32'h0);
        tick();
        chk("R10 source returns", 32'(irq), 32'h1);
        rd_chk("R6 mask readback", 8'h10, 32'h10);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule